// File: doc/BRIEF.md
# Burst Flash Read Interface Sequencer

This block is the device-side bus logic of a 16-bit NOR-style read memory whose low sixteen address bits share pins with the data bus, while six upper address bits arrive on their own inputs. It turns the chip-select, output-gate, write-strobe, address-strobe, reset and bus-clock inputs into bus operations. These are asynchronous single-word reads, clocked burst reads and command writes. It also drives the read word, together with an output-enable flag that the pad ring uses for high impedance.

The block runs on a free-running core clock `clk`. All bus inputs are synchronous to it, and the bus clock `fclk` is sampled as a level, with its rising edges detected internally. After reset the block serves asynchronous reads. A rising bus-clock edge seen while the address strobe is low starts a burst. The burst waits a configurable number of bus-clock edges and then presents one word per edge, counting either linearly across the whole space or wrapping inside an aligned group of 8, 16 or 32 words. The burst settings and a sticky power-saving flag are written through command writes. The array is a computed behavioural word source.

The bus has no back-pressure. The host paces a burst with bus-clock edges, and `rdy` acts as the valid flag of the first word.

Top module: `bfl_read_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, no burst is active: `rdy`=1, `dq_oe`=0 and `pwr_save`=0. The burst settings return to a wait of 7 edges in continuous mode.
- R2: With `ce_n` low and `adv_n` low, the address {`addr_hi`,`dq_in`} is captured on each core clock edge, so the value held when `adv_n` rises is kept. Outside a burst, `dq_out` shows the array word of that address. The word at address A is A[15:0] XOR (A[21:16] shifted left by 10).
- R3: `dq_oe` is 1 only when `ce_n`=0, `oe_n`=0, `we_n`=1 and `rst_n`=1 and, inside a burst, only once `rdy` is 1.
- R4: A rising edge of `fclk` with `ce_n`=0 and `adv_n`=0 starts a burst at the captured address, and `rdy` goes to 0.
- R5: With a configured wait W, the W-th later rising `fclk` edge (with `ce_n`=0 and `adv_n`=1) makes `rdy` 1 and `dq_out` the word at the start address. `rdy` stays 0 after the earlier edges.
- R6: Mode code 0 (continuous): each later edge steps the full 22-bit address by one, and 0x3FFFFF rolls over to 0.
- R7: Mode codes 1, 2 and 3 step only the low 3, 4 or 5 address bits (groups of 8, 16 or 32 words). The upper bits stay fixed.
- R8: A bus-clock edge with `oe_n`=1 during the data phase does not advance the address.
- R9: `ce_n`=1 at a core clock edge ends the burst: `rdy` returns to 1 and `dq_oe` is 0.
- R10: A bus-clock edge with `adv_n`=0 during a burst ends it and restarts from the new address, with the full wait count.
- R11: A write (a rising `we_n` with `ce_n`=0) of 0x0060, followed by a write of a configuration word, sets wait = bits[2:0] (values below 2 become 2) and mode = bits[4:3].
- R12: A write of 0x00B9 sets `pwr_save`. No command clears it; only `rst_n` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low; command taken on its rise |
| adv_n | input | 1 | Address strobe, active low |
| fclk | input | 1 | Bus clock level, rising edges detected |
| addr_hi | input | 6 | Upper address bits |
| dq_in | input | 16 | Shared bus, incoming address or command data |
| dq_out | output | 16 | Read word toward the shared bus |
| dq_oe | output | 1 | Drive enable for the shared bus (0 = high impedance) |
| rdy | output | 1 | Low while a burst waits for its first word |
| pwr_save | output | 1 | Sticky power-saving flag |

## Verification
On every cycle, the checker confirms that the bus is never driven while select or the output gate is inactive or a write is in progress. It also confirms that a burst start always drops `rdy`, that `rdy` only rises after a bus-clock edge or a deselect, and that the power-saving flag never clears outside reset. The bench scenarios cover what depends on configured values and address arithmetic. These are the exact wait count, the clamp of short waits, the continuous rollover at the top of the space, the wrap inside 8-, 16- and 32-word groups, the hold when the output gate is high, and a restart mid-burst.

// File: rtl/bfl_pkg.sv
package bfl_pkg;
  localparam int ADDR_W = 22;
  localparam int DATA_W = 16;
  localparam int WAIT_W = 3;

  typedef enum logic [1:0] {
    BM_LINEAR = 2'd0,
    BM_WRAP8  = 2'd1,
    BM_WRAP16 = 2'd2,
    BM_WRAP32 = 2'd3
  } bmode_t;

  typedef struct packed {
    logic [WAIT_W-1:0] wait_n;
    bmode_t            mode;
  } bcfg_t;
endpackage

// File: rtl/bfl_array.sv
module bfl_array #(
  parameter int AW = 22,
  parameter int DW = 16
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);
  localparam int HW = AW - DW;
  localparam int SH = DW - HW;

  // computed word source: low half XOR upper bits moved to the top
  always_comb begin
    word = addr[DW-1:0] ^ {addr[AW-1:DW], {SH{1'b0}}};
  end
endmodule

// File: rtl/bfl_cmd.sv
module bfl_cmd
  import bfl_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          WW       = 3,
  parameter logic [15:0] OP_CFG   = 16'h0060,
  parameter logic [15:0] OP_PSAVE = 16'h00B9,
  parameter int          WAIT_MIN = 2,
  parameter int          WAIT_RST = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  output bcfg_t         cfg,
  output logic          pwr_save
);
  localparam logic [WW-1:0] WMIN = WW'(WAIT_MIN);
  localparam logic [WW-1:0] WRST = WW'(WAIT_RST);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      cfg.wait_n <= WRST;
      cfg.mode   <= BM_LINEAR;
      pwr_save   <= 1'b0;
    end else if (wr_stb) begin
      if (armed) begin
        armed      <= 1'b0;
        cfg.wait_n <= (wr_data[WW-1:0] < WMIN) ? WMIN : wr_data[WW-1:0];
        cfg.mode   <= bmode_t'(wr_data[WW+1:WW]);
      end else if (wr_data == DW'(OP_CFG)) begin
        armed <= 1'b1;
      end else begin
        armed <= 1'b0;
        if (wr_data == DW'(OP_PSAVE)) pwr_save <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bfl_burst.sv
module bfl_burst
  import bfl_pkg::*;
#(
  parameter int AW = 22,
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_edge,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          adv_n,
  input  logic [AW-1:0] start_addr,
  input  bcfg_t         cfg,
  output logic          active,
  output logic          first_ok,
  output logic [AW-1:0] cur_addr
);
  logic [WW-1:0] wait_cnt;
  logic [AW-1:0] nxt_addr;

  // next address: the mode selects how many low bits may count
  always_comb begin
    logic [AW-1:0] inc;
    logic [AW-1:0] mask;
    inc = cur_addr + AW'(1);
    unique case (cfg.mode)
      BM_WRAP8:  mask = AW'(7);
      BM_WRAP16: mask = AW'(15);
      BM_WRAP32: mask = AW'(31);
      default:   mask = '1;
    endcase
    nxt_addr = (cur_addr & ~mask) | (inc & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      first_ok <= 1'b0;
      wait_cnt <= '0;
      cur_addr <= '0;
    end else if (ce_n) begin
      active   <= 1'b0;
      first_ok <= 1'b0;
    end else if (bus_edge && !adv_n) begin
      active   <= 1'b1;
      first_ok <= 1'b0;
      wait_cnt <= cfg.wait_n;
      cur_addr <= start_addr;
    end else if (bus_edge && active) begin
      if (!first_ok) begin
        if (wait_cnt == WW'(1)) first_ok <= 1'b1;
        wait_cnt <= wait_cnt - WW'(1);
      end else if (!oe_n) begin
        cur_addr <= nxt_addr;
      end
    end
  end
endmodule

// File: rtl/bfl_read_seq.sv
module bfl_read_seq
  import bfl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int WW = WAIT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic             adv_n,
  input  logic             fclk,
  input  logic [AW-DW-1:0] addr_hi,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic             rdy,
  output logic             pwr_save
);
  logic          fclk_q;
  logic          we_q;
  logic [AW-1:0] lat_addr;
  logic [AW-1:0] bst_addr;
  logic [AW-1:0] rd_addr;
  logic          bus_edge;
  logic          wr_stb;
  logic          b_active;
  logic          b_first;
  bcfg_t         cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fclk_q   <= 1'b1;
      we_q     <= 1'b1;
      lat_addr <= '0;
    end else begin
      fclk_q <= fclk;
      we_q   <= we_n;
      if (!ce_n && !adv_n) lat_addr <= {addr_hi, dq_in};
    end
  end

  assign bus_edge = fclk && !fclk_q;
  assign wr_stb   = we_n && !we_q && !ce_n;

  bfl_cmd #(.DW(DW), .WW(WW)) cmd_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(dq_in),
    .cfg(cfg), .pwr_save(pwr_save)
  );

  bfl_burst #(.AW(AW), .WW(WW)) burst_i (
    .clk(clk), .rst_n(rst_n), .bus_edge(bus_edge), .ce_n(ce_n),
    .oe_n(oe_n), .adv_n(adv_n), .start_addr({addr_hi, dq_in}),
    .cfg(cfg), .active(b_active), .first_ok(b_first), .cur_addr(bst_addr)
  );

  assign rd_addr = b_active ? bst_addr : lat_addr;

  bfl_array #(.AW(AW), .DW(DW)) array_i (.addr(rd_addr), .word(dq_out));

  assign rdy   = !b_active || b_first;
  assign dq_oe = !ce_n && !oe_n && we_n && rst_n && rdy;
endmodule

// File: rtl/bfl_read_seq_chk.sv
module bfl_read_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic adv_n,
  input logic fclk,
  input logic dq_oe,
  input logic rdy,
  input logic pwr_save
);
  logic fclk_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fclk_d <= 1'b1;
    else        fclk_d <= fclk;
  end

  // R3: drive only when selected, gated and not writing
  a_r3_drive_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!ce_n && !oe_n && we_n));

  // R4: a burst start always withdraws ready
  a_r4_start_drops_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    (fclk && !fclk_d && !adv_n && !ce_n) |=> !rdy);

  // R5: ready rises only after a bus-clock edge or a deselect
  a_r5_rdy_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy ##1 rdy) |-> ($past(fclk && !fclk_d) || $past(ce_n)));

  // R9: deselect ends any burst
  a_r9_deselect_ends: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> (rdy && !dq_oe));

  // R12: power-saving flag is sticky outside reset
  a_r12_psave_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_save |=> pwr_save);
endmodule

bind bfl_read_seq bfl_read_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .adv_n(adv_n), .fclk(fclk), .dq_oe(dq_oe), .rdy(rdy), .pwr_save(pwr_save)
);

// File: tb/bfl_read_seq_tb_top.sv
module bfl_read_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, adv_n = 1'b1, fclk = 1'b0;
  logic [5:0]  addr_hi = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic dq_oe, rdy, pwr_save;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bfl_read_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .adv_n(adv_n), .fclk(fclk), .addr_hi(addr_hi), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .rdy(rdy), .pwr_save(pwr_save)
  );

  typedef struct packed {
    logic [21:0] a;
    logic        we;
  } avec_t;

  localparam avec_t VECS [6] = '{
    '{22'h000000, 1'b1}, '{22'h3FFFFF, 1'b1}, '{22'h12ABCD, 1'b1},
    '{22'h2C0F0F, 1'b0}, '{22'h015555, 1'b1}, '{22'h3A7001, 1'b0}
  };

  function automatic logic [15:0] word_of(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], 10'b0};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [21:0] a);
    addr_hi = a[21:16];
    dq_in   = a[15:0];
  endtask

  task automatic bedge();
    fclk = 1'b1; cyc();
    fclk = 1'b0; cyc();
  endtask

  task automatic write_cmd(input logic [15:0] d);
    ce_n = 1'b0; we_n = 1'b0; dq_in = d; cyc();
    we_n = 1'b1; cyc();
    ce_n = 1'b1; cyc();
  endtask

  task automatic set_cfg(input logic [15:0] d);
    write_cmd(16'h0060);
    write_cmd(d);
  endtask

  task automatic burst_start(input logic [21:0] a, input string req);
    ce_n = 1'b0; adv_n = 1'b0; oe_n = 1'b1; set_addr(a); cyc();
    fclk = 1'b1; cyc();
    fclk = 1'b0; adv_n = 1'b1; oe_n = 1'b0; dq_in = 16'h0; cyc();
    check(req, {31'b0, rdy}, 32'h0);
  endtask

  task automatic wait_first(input int w, input logic [21:0] a, input string req);
    for (int i = 1; i <= w; i++) begin
      bedge();
      if (i < w) check(req, {31'b0, rdy}, 32'h0);
    end
    check(req, {31'b0, rdy}, 32'h1);
    check(req, {16'b0, dq_out}, {16'b0, word_of(a)});
    check(req, {31'b0, dq_oe}, 32'h1);
  endtask

  task automatic next_word(input logic [21:0] a, input string req);
    bedge();
    check(req, {16'b0, dq_out}, {16'b0, word_of(a)});
  endtask

  task automatic end_burst();
    ce_n = 1'b1; oe_n = 1'b1; cyc();
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    // R1: reset state
    check("R1 rdy", {31'b0, rdy}, 32'h1);
    check("R1 dq_oe", {31'b0, dq_oe}, 32'h0);
    check("R1 pwr_save", {31'b0, pwr_save}, 32'h0);
    rst_n = 1'b1; cyc();

    // R2 / R3: table of asynchronous reads
    for (int k = 0; k < 6; k++) begin
      ce_n = 1'b0; adv_n = 1'b0; set_addr(VECS[k].a); cyc();
      adv_n = 1'b1; dq_in = 16'h1111; oe_n = 1'b0; we_n = VECS[k].we; cyc();
      check("R3 drive", {31'b0, dq_oe}, {31'b0, VECS[k].we});
      if (VECS[k].we) check("R2 word", {16'b0, dq_out}, {16'b0, word_of(VECS[k].a)});
      we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b1; cyc();
    end

    // R1 default wait 7, R6 continuous rollover
    burst_start(22'h3FFFFE, "R4 start");
    wait_first(7, 22'h3FFFFE, "R5 default wait");
    next_word(22'h3FFFFF, "R6 step");
    next_word(22'h000000, "R6 rollover");
    end_burst();
    check("R9 ends rdy", {31'b0, rdy}, 32'h1);
    check("R9 ends oe", {31'b0, dq_oe}, 32'h0);

    // R11 wait 3 wrap8, R7, R8
    set_cfg(16'h000B);
    burst_start(22'h00012D, "R4 start");
    wait_first(3, 22'h00012D, "R11 wait3");
    oe_n = 1'b1; bedge(); oe_n = 1'b0; cyc();
    check("R8 hold", {16'b0, dq_out}, {16'b0, word_of(22'h00012D)});
    next_word(22'h00012E, "R7 wrap8");
    next_word(22'h00012F, "R7 wrap8");
    next_word(22'h000128, "R7 wrap8 wrap");
    // R10 restart mid-burst
    burst_start(22'h200300, "R10 restart");
    wait_first(3, 22'h200300, "R10 restart wait");
    end_burst();

    // R11 clamp to 2, wrap16
    set_cfg(16'h0010);
    burst_start(22'h000A0E, "R4 start");
    wait_first(2, 22'h000A0E, "R11 clamp");
    next_word(22'h000A0F, "R7 wrap16");
    next_word(22'h000A00, "R7 wrap16 wrap");
    end_burst();

    // wrap32 wait 4
    set_cfg(16'h001C);
    burst_start(22'h12345F, "R4 start");
    wait_first(4, 22'h12345F, "R11 wait4");
    next_word(22'h123440, "R7 wrap32 wrap");
    next_word(22'h123441, "R7 wrap32");

    // R1 / R3: reset mid-burst
    rst_n = 1'b0; cyc();
    check("R3 reset oe", {31'b0, dq_oe}, 32'h0);
    check("R1 reset rdy", {31'b0, rdy}, 32'h1);
    rst_n = 1'b1; end_burst();
    burst_start(22'h000040, "R4 start");
    wait_first(7, 22'h000040, "R1 default restored");
    end_burst();

    // R12 sticky power-saving flag
    write_cmd(16'h00B9);
    check("R12 set", {31'b0, pwr_save}, 32'h1);
    set_cfg(16'h0003);
    write_cmd(16'h0000);
    check("R12 sticky", {31'b0, pwr_save}, 32'h1);
    rst_n = 1'b0; cyc(); rst_n = 1'b1; cyc();
    check("R12 reset clears", {31'b0, pwr_save}, 32'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule